// File: doc/BRIEF.md
# Hybrid Local-History Branch Predictor

This block sits in the fetch stage and gives a direction, a target and a redirect cost for the branch that is being fetched, in the same cycle. The direction of a conditional branch comes from a direct-mapped table of tagged entries. Each entry holds a short shift register with the recent outcomes of that branch, and a private set of 2-bit saturating counters that the shift register selects. This is a two-level local scheme. When no entry matches the fetch address, a fixed rule takes over. A branch with a negative displacement (backward) is predicted taken, and one with a zero or positive displacement (forward) is predicted not taken.

Unconditional jumps, calls and returns are always predicted taken. A circular return-address stack supplies the target of a return. Calls push the address that follows them, and returns pop. A separate resolve port feeds back the real outcome of conditional branches. A matching entry learns that outcome. A missing entry is allocated, overwriting whatever held its slot.

The penalty output is a plain cycle count. Fetch adds it to its own schedule: 0 for a dynamically predicted fall-through, 1 for a predicted redirect (the one-cycle bubble), and 6 whenever the fixed rule made the call.

Top module: `hybrid_bp`

## Requirements
- R1: A conditional fetch hits when the entry at index `fetch_pc[ALIGN +: IDX_W]` is valid and its stored tag equals `fetch_pc[ALIGN+IDX_W +: TAG_W]`. On a hit the predicted direction is bit 1 of the counter selected by that entry's history.
- R2: On a dynamic hit, a predicted-taken branch reports a penalty of 1 and a predicted-not-taken branch reports 0. `pred_static` is 0.
- R3: A conditional fetch that misses is predicted taken exactly when `fetch_disp` bit AW-1 is 1. It reports a penalty of 6 with `pred_static` = 1.
- R4: For the conditional, jump and call kinds, `pred_target` equals `fetch_pc + fetch_disp` modulo 2^AW.
- R5: The branch kind is encoded as 0 conditional, 1 jump, 2 call, 3 return. Jump, call and return are predicted taken with a penalty of 1.
- R6: A resolve that hits first updates the counter selected by the entry's old history, saturating at 0 and 3 (up when taken, down when not). It then shifts the outcome into bit 0 of the history.
- R7: A resolve that misses writes the valid bit and the tag, sets the history to the outcome in bit 0 with zeros above it, and sets every counter of the entry to 2 if the outcome was taken and to 1 if it was not.
- R8: A valid call fetch pushes `fetch_pc + INSN_BYTES`. A valid return fetch predicts the most recently pushed address that has not yet been popped, and pops it.
- R9: The return stack holds RS_DEPTH addresses. A push onto a full stack overwrites the oldest one, so the following RS_DEPTH returns yield the latest RS_DEPTH pushes, newest first.
- R10: After reset every table entry is invalid, and every return-stack slot holds 0 with the pointer at slot 0.
- R11: While `fetch_valid` is 0, `pred_taken`, `pred_static` and `pred_penalty` are 0 and the return stack does not change. Resolves still update the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A branch is being fetched this cycle |
| fetch_pc | input | AW | Address of the fetched branch |
| fetch_kind | input | 2 | Branch kind: 0 cond, 1 jump, 2 call, 3 return |
| fetch_disp | input | AW | Two's-complement displacement to the branch target |
| upd_valid | input | 1 | A conditional branch has resolved |
| upd_pc | input | AW | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | AW | Predicted target address |
| pred_penalty | output | 3 | Redirect cost in cycles (0, 1 or 6) |
| pred_static | output | 1 | The fixed displacement-sign rule made the prediction |

## Verification
The bench builds the block with AW=16, IDX_W=3, TAG_W=2, HIST_W=4 and RS_DEPTH=4. With these values, fetch addresses below 128 cover every index with four competing tags, so tag misses, allocations that evict a live entry, and history wrap-around all occur many times within a few thousand cycles. The four-slot return stack makes overflow and wrap reachable with a handful of calls. A long pseudo-random mix of fetches and resolves over that address space is compared, every cycle, against an arithmetic model of the entries and the stack. Directed sequences pin down allocation, counter walk, the static rule, idle fetch and stack overflow with constant expected values.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        BK_COND = 2'd0,
        BK_JUMP = 2'd1,
        BK_CALL = 2'd2,
        BK_RET  = 2'd3
    } br_kind_e;

    localparam logic [2:0] PEN_NONE   = 3'd0;
    localparam logic [2:0] PEN_BUBBLE = 3'd1;
    localparam logic [2:0] PEN_STATIC = 3'd6;

endpackage

// File: rtl/bp_local_table.sv
module bp_local_table #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 8,
    parameter int HIST_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W+TAG_W-1:0]   lk_key,
    output logic                     lk_hit,
    output logic                     lk_taken,
    input  logic                     up_valid,
    input  logic [IDX_W+TAG_W-1:0]   up_key,
    input  logic                     up_taken
);
    localparam int NENT = 1 << IDX_W;
    localparam int NCTR = 1 << HIST_W;

    typedef struct packed {
        logic                   valid;
        logic [TAG_W-1:0]       tag;
        logic [HIST_W-1:0]      hist;
        logic [NCTR-1:0][1:0]   ctr;
    } entry_t;

    entry_t [NENT-1:0] tbl_q, tbl_d;

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    entry_t            lk_ent, up_ent;
    logic              up_hit;
    logic [HIST_W-1:0] up_hist;
    logic [1:0]        up_ctr;

    assign lk_idx = lk_key[IDX_W-1:0];
    assign lk_tag = lk_key[IDX_W +: TAG_W];
    assign up_idx = up_key[IDX_W-1:0];
    assign up_tag = up_key[IDX_W +: TAG_W];

    assign lk_ent   = tbl_q[lk_idx];
    assign lk_hit   = lk_ent.valid && (lk_ent.tag == lk_tag);
    assign lk_taken = lk_ent.ctr[lk_ent.hist][1];

    assign up_ent  = tbl_q[up_idx];
    assign up_hit  = up_ent.valid && (up_ent.tag == up_tag);
    assign up_hist = up_ent.hist;
    assign up_ctr  = up_ent.ctr[up_ent.hist];

    function automatic logic [1:0] sat_step(input logic [1:0] c, input logic t);
        if (t) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    always_comb begin
        tbl_d = tbl_q;
        if (up_valid) begin
            if (up_hit) begin
                tbl_d[up_idx].ctr[up_hist] = sat_step(up_ctr, up_taken);
                tbl_d[up_idx].hist         = {up_hist[HIST_W-2:0], up_taken};
            end else begin
                tbl_d[up_idx].valid = 1'b1;
                tbl_d[up_idx].tag   = up_tag;
                tbl_d[up_idx].hist  = HIST_W'(up_taken);
                tbl_d[up_idx].ctr   = {NCTR{up_taken ? 2'b10 : 2'b01}};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // R7
    alloc_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && !up_hit |=> tbl_q[$past(up_idx)].valid &&
                                tbl_q[$past(up_idx)].tag == $past(up_tag));

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_hit |=> tbl_q[$past(up_idx)].hist[0] == $past(up_taken));

    // R6
    ctr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_hit && up_taken && up_ctr == 2'b11
        |=> tbl_q[$past(up_idx)].ctr[$past(up_hist)] == 2'b11);

endmodule

// File: rtl/bp_ret_stack.sv
module bp_ret_stack #(
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] slot;
        logic [PTR_W-1:0]         ptr;
    } rs_state_t;

    rs_state_t        st_q, st_d;
    logic [PTR_W-1:0] top_ptr;

    assign top_ptr  = st_q.ptr - PTR_W'(1);
    assign top_addr = st_q.slot[top_ptr];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slot[st_q.ptr] = push_addr;
            st_d.ptr            = st_q.ptr + PTR_W'(1);
        end else if (pop) begin
            st_d.ptr = top_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top_addr == $past(push_addr));

endmodule

// File: rtl/hybrid_bp.sv
module hybrid_bp
    import bp_pkg::*;
#(
    parameter int AW         = 32,
    parameter int IDX_W      = 6,
    parameter int TAG_W      = 8,
    parameter int HIST_W     = 4,
    parameter int RS_DEPTH   = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    input  logic [1:0]    fetch_kind,
    input  logic [AW-1:0] fetch_disp,
    input  logic          upd_valid,
    input  logic [AW-1:0] upd_pc,
    input  logic          upd_taken,
    output logic          pred_taken,
    output logic [AW-1:0] pred_target,
    output logic [2:0]    pred_penalty,
    output logic          pred_static
);
    localparam int ALIGN = $clog2(INSN_BYTES);
    localparam int KEY_W = IDX_W + TAG_W;

    logic          lk_hit, lk_taken;
    logic          rs_push, rs_pop;
    logic [AW-1:0] rs_top;
    logic          unused_bits;

    assign unused_bits = ^{upd_pc[AW-1:ALIGN+KEY_W], upd_pc[ALIGN-1:0]};

    bp_local_table #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .HIST_W(HIST_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_key  (fetch_pc[ALIGN +: KEY_W]),
        .lk_hit  (lk_hit),
        .lk_taken(lk_taken),
        .up_valid(upd_valid),
        .up_key  (upd_pc[ALIGN +: KEY_W]),
        .up_taken(upd_taken)
    );

    bp_ret_stack #(
        .AW   (AW),
        .DEPTH(RS_DEPTH)
    ) u_rstack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rs_push),
        .pop      (rs_pop),
        .push_addr(fetch_pc + AW'(INSN_BYTES)),
        .top_addr (rs_top)
    );

    always_comb begin
        pred_taken   = 1'b0;
        pred_static  = 1'b0;
        pred_penalty = PEN_NONE;
        pred_target  = fetch_pc + fetch_disp;
        rs_push      = 1'b0;
        rs_pop       = 1'b0;
        if (fetch_valid) begin
            case (br_kind_e'(fetch_kind))
                BK_COND: begin
                    if (lk_hit) begin
                        pred_taken   = lk_taken;
                        pred_penalty = lk_taken ? PEN_BUBBLE : PEN_NONE;
                    end else begin
                        pred_static  = 1'b1;
                        pred_taken   = fetch_disp[AW-1];
                        pred_penalty = PEN_STATIC;
                    end
                end
                BK_JUMP: begin
                    pred_taken   = 1'b1;
                    pred_penalty = PEN_BUBBLE;
                end
                BK_CALL: begin
                    pred_taken   = 1'b1;
                    pred_penalty = PEN_BUBBLE;
                    rs_push      = 1'b1;
                end
                default: begin
                    pred_taken   = 1'b1;
                    pred_penalty = PEN_BUBBLE;
                    pred_target  = rs_top;
                    rs_pop       = 1'b1;
                end
            endcase
        end
    end

    // R3
    static_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_static |-> pred_penalty == PEN_STATIC && fetch_kind == BK_COND && !lk_hit);

    // R2
    hit_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && fetch_kind == BK_COND && lk_hit
        |-> !pred_static && pred_penalty != PEN_STATIC);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !pred_taken && !pred_static && pred_penalty == PEN_NONE);

endmodule

// File: tb/tb_hybrid_bp.sv
module tb_hybrid_bp;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic [1:0]    fetch_kind = '0;
    logic [AW-1:0] fetch_disp = '0;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic          pred_taken;
    logic [AW-1:0] pred_target;
    logic [2:0]    pred_penalty;
    logic          pred_static;

    int checks = 0;
    int errors = 0;

    logic        mv [8];
    logic [1:0]  mt [8];
    logic [3:0]  mh [8];
    logic [1:0]  mc [8][16];
    logic [15:0] ms [4];
    logic [1:0]  mp;
    logic [31:0] seed = 32'h1234_abcd;

    always #5 clk = ~clk;

    hybrid_bp #(
        .AW(AW), .IDX_W(3), .TAG_W(2), .HIST_W(4), .RS_DEPTH(4), .INSN_BYTES(4)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_kind(fetch_kind),
        .fetch_disp(fetch_disp), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .pred_taken(pred_taken), .pred_target(pred_target),
        .pred_penalty(pred_penalty), .pred_static(pred_static)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic step(input logic fv, input logic [15:0] pc, input logic [1:0] kd,
                        input logic [15:0] dp, input logic uv, input logic [15:0] upc,
                        input logic ut);
        logic [2:0]  ix, ui;
        logic [1:0]  tg, ug, tp, c;
        logic        hit, e_tk, e_st;
        logic [15:0] e_tg;
        logic [2:0]  e_pen;
        string       rq;
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; fetch_kind = kd; fetch_disp = dp;
        upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        ix = pc[4:2]; tg = pc[6:5];
        hit = mv[ix] && (mt[ix] == tg);
        tp = mp - 2'd1;
        e_tg = pc + dp; e_tk = 1'b0; e_st = 1'b0; e_pen = 3'd0; rq = "R11";
        if (fv) begin
            case (kd)
                2'd0: if (hit) begin
                          e_tk = mc[ix][mh[ix]][1]; e_pen = e_tk ? 3'd1 : 3'd0; rq = "R1/R2";
                      end else begin
                          e_st = 1'b1; e_tk = dp[15]; e_pen = 3'd6; rq = "R3";
                      end
                2'd3: begin e_tk = 1'b1; e_pen = 3'd1; e_tg = ms[tp]; rq = "R8"; end
                default: begin e_tk = 1'b1; e_pen = 3'd1; rq = "R5"; end
            endcase
        end
        chk(rq, 32'(pred_taken), 32'(e_tk));
        chk(rq, 32'(pred_penalty), 32'(e_pen));
        chk(rq, 32'(pred_static), 32'(e_st));
        if (fv) chk((kd == 2'd3) ? "R8" : "R4", 32'(pred_target), 32'(e_tg));
        if (fv && kd == 2'd2) begin ms[mp] = pc + 16'd4; mp = mp + 2'd1; end
        else if (fv && kd == 2'd3) mp = tp;
        if (uv) begin
            ui = upc[4:2]; ug = upc[6:5];
            if (mv[ui] && mt[ui] == ug) begin
                c = mc[ui][mh[ui]];
                if (ut) begin if (c != 2'd3) c = c + 2'd1; end
                else if (c != 2'd0) c = c - 2'd1;
                mc[ui][mh[ui]] = c;
                mh[ui] = {mh[ui][2:0], ut};
            end else begin
                mv[ui] = 1'b1; mt[ui] = ug; mh[ui] = {3'b000, ut};
                for (int k = 0; k < 16; k++) mc[ui][k] = ut ? 2'd2 : 2'd1;
            end
        end
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            mv[i] = 1'b0; mt[i] = '0; mh[i] = '0;
            for (int k = 0; k < 16; k++) mc[i][k] = '0;
        end
        for (int i = 0; i < 4; i++) ms[i] = '0;
        mp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 / R11: quiet outputs, every index misses, empty stack reads 0
        step(1'b0, 16'h0000, 2'd0, 16'h0000, 1'b0, 16'h0, 1'b0);
        for (int i = 0; i < 32; i++)
            step(1'b1, 16'(i * 4), 2'd0, (i % 2 == 1) ? 16'hFFE0 : 16'h0020, 1'b0, 16'h0, 1'b0);
        step(1'b1, 16'h0200, 2'd3, 16'h0, 1'b0, 16'h0, 1'b0);
        chk("R10", 32'(pred_target), 32'h0);
        step(1'b1, 16'h0204, 2'd2, 16'h0, 1'b0, 16'h0, 1'b0);
        step(1'b1, 16'h0208, 2'd3, 16'h0, 1'b0, 16'h0, 1'b0);

        // R7: allocation taken predicts taken with bubble
        step(1'b0, 16'h0, 2'd0, 16'h0, 1'b1, 16'h0070, 1'b1);
        step(1'b1, 16'h0070, 2'd0, 16'h0020, 1'b0, 16'h0, 1'b0);
        chk("R7", 32'(pred_taken), 32'd1);
        chk("R7", 32'(pred_penalty), 32'd1);
        // R6: N,N,N,T walk brings history back to 0001 whose counter fell to 1
        step(1'b0, 16'h0, 2'd0, 16'h0, 1'b1, 16'h0070, 1'b0);
        step(1'b0, 16'h0, 2'd0, 16'h0, 1'b1, 16'h0070, 1'b0);
        step(1'b0, 16'h0, 2'd0, 16'h0, 1'b1, 16'h0070, 1'b0);
        step(1'b0, 16'h0, 2'd0, 16'h0, 1'b1, 16'h0070, 1'b1);
        step(1'b1, 16'h0070, 2'd0, 16'hFF00, 1'b0, 16'h0, 1'b0);
        chk("R6", 32'(pred_taken), 32'd0);
        chk("R6", 32'(pred_penalty), 32'd0);
        // R7: allocation not taken
        step(1'b0, 16'h0, 2'd0, 16'h0, 1'b1, 16'h0078, 1'b0);
        step(1'b1, 16'h0078, 2'd0, 16'hFFF0, 1'b0, 16'h0, 1'b0);
        chk("R7", 32'(pred_taken), 32'd0);
        chk("R7", 32'(pred_static), 32'd0);
        // R1: same index, other tag misses and falls to the static rule
        step(1'b1, 16'h0010, 2'd0, 16'hFFF0, 1'b0, 16'h0, 1'b0);
        chk("R1", 32'(pred_static), 32'd1);
        chk("R3", 32'(pred_target), 32'h0000);
        // R5: jump
        step(1'b1, 16'h0100, 2'd1, 16'h0040, 1'b0, 16'h0, 1'b0);
        chk("R5", 32'(pred_target), 32'h0140);

        // R9: five calls into a four-slot stack, four returns newest first
        for (int i = 0; i < 5; i++)
            step(1'b1, 16'(16'h0400 + i * 16), 2'd2, 16'h0800, 1'b0, 16'h0, 1'b0);
        for (int i = 4; i >= 1; i--) begin
            step(1'b1, 16'h0600, 2'd3, 16'h0, 1'b0, 16'h0, 1'b0);
            chk("R9", 32'(pred_target), 32'(16'h0404 + i * 16));
        end
        // R11: an invalid call fetch does not push
        step(1'b1, 16'h0A00, 2'd2, 16'h0, 1'b0, 16'h0, 1'b0);
        step(1'b0, 16'h0B00, 2'd2, 16'h0, 1'b0, 16'h0, 1'b0);
        step(1'b1, 16'h0C00, 2'd3, 16'h0, 1'b0, 16'h0, 1'b0);
        chk("R11", 32'(pred_target), 32'h0A04);

        // R1 R2 R3 R4 R5 R6 R7 R8: mixed sweep against the model
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r1, r2;
            logic [1:0]  kd;
            r1 = rnd(); r2 = rnd();
            kd = (r1[2:1] == 2'b00) ? r1[4:3] : 2'd0;
            step(r1[0] | r1[5], {9'd0, r1[12:8], 2'b00}, kd, r2[15:0],
                 r1[13] | r1[14], {9'd0, r1[20:16], 2'b00},
                 (r1[22:21] != 2'b00) ^ r1[23]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule